// File: doc/BRIEF.md
# Windowed Multiport Register File

This block is the general purpose register storage of a RISC integer core. Every register is 32 bits wide. Each operand address is 8 bits. When bit 7 of an address is 0, bits 6:0 name a global register directly. Only globals 64 to 127 have storage behind them. When bit 7 is 1, bits 6:0 are an offset that is added, modulo 128, to a programmable 7-bit window base. The sum picks one of 128 local registers. Because of this, a called routine can move its window without copying any data.

Two combinational read ports serve the operand fetch of an instruction. The integer write port carries the result of the previous cycle's operation. A second write port, used only by the floating-point unit, lets long-latency results retire in any cycle without taking the integer slot. Both writes land on the same clock edge. A read of a register that is being written in that cycle sees the incoming value.

Reads of the unimplemented globals 0 to 63 return zero. Writes to them are dropped and reported on a one-cycle flag. A second one-cycle flag reports when both write ports hit the same physical register.

Top module: `windowed_regfile`

## Requirements
- R1: With address bit 7 = 0 and address 64 to 127, a read returns global register (address - 64), which holds the last value written to that address.
- R2: A read of any address 0 to 63 returns 32'h0.
- R3: A write (integer or floating-point port) to an address 0 to 63 changes no register, and unimplFlag is 1 in the cycle after that write and 0 otherwise.
- R4: With address bit 7 = 1, the accessed local register is number (localBase + address[6:0]) mod 128, and the sum wraps past 127.
- R5: When baseWrEn is 1 at a rising edge, localBase takes baseWrData from the next cycle on. Reset sets localBase to 0.
- R6: Both read ports return their own addressed registers in the same cycle, independently.
- R7: An integer write with intWrEn = 1 is stored at the rising edge and is read back in later cycles.
- R8: Integer and floating-point writes to different registers in one cycle are both stored.
- R9: A read of a register that is being written in the current cycle returns the write data. If both ports write it, the floating-point data is returned.
- R10: If both write ports target the same implemented register in one cycle, the floating-point data is stored, and collisionFlag is 1 in the next cycle only.
- R11: While rst is 1 at a rising edge, both flags are cleared to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| baseWrEn | input | 1 | Load the local window base |
| baseWrData | input | 7 | New local window base |
| rdAddrA | input | 8 | Read port A operand address |
| rdAddrB | input | 8 | Read port B operand address |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdDataB | output | 32 | Read port B data (combinational) |
| intWrEn | input | 1 | Integer write enable |
| intWrAddr | input | 8 | Integer write address |
| intWrData | input | 32 | Integer write data |
| fpWrEn | input | 1 | Floating-point write enable |
| fpWrAddr | input | 8 | Floating-point write address |
| fpWrData | input | 32 | Floating-point write data |
| unimplFlag | output | 1 | One-cycle pulse after a write to globals 0 to 63 |
| collisionFlag | output | 1 | One-cycle pulse after both ports wrote the same register |

## Verification
Two things can happen in the same cycle: an integer write-back and a floating-point write-back. They can go to the same register, and a read of that register can happen alongside them. The random stimulus often copies the integer write address into the floating-point address and the read addresses. Directed cycles force an exact same-register clash inside the local window. A bench model applies the integer write before the floating-point write and gives floating-point data priority for reads in the same cycle. It is then compared with the read data in that cycle, with the stored value in later cycles, and with the collision pulse on the next cycle.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int DATA_W      = 32;
  localparam int OPADDR_W    = 8;
  localparam int OFFSET_W    = OPADDR_W - 1;
  localparam int LOCAL_DEPTH = 1 << OFFSET_W;
  localparam int LOCAL_W     = $clog2(LOCAL_DEPTH);
  localparam int GLOBAL_LO   = 64;
  localparam int GLOBAL_CNT  = (1 << OFFSET_W) - GLOBAL_LO;
  localparam int PHYS_DEPTH  = GLOBAL_CNT + LOCAL_DEPTH;
  localparam int PHYS_W      = $clog2(PHYS_DEPTH);
  localparam int NUM_RD      = 2;

  typedef struct packed {
    logic              valid;
    logic [PHYS_W-1:0] idx;
  } decode_t;

  typedef struct packed {
    logic                           intWe;
    logic                           fpWe;
    logic [PHYS_W-1:0]              intIdx;
    logic [PHYS_W-1:0]              fpIdx;
    logic [NUM_RD-1:0]              rdValid;
    logic [NUM_RD-1:0][PHYS_W-1:0]  rdIdx;
  } rfStrobes_t;

  // Physical map: globals at 0..GLOBAL_CNT-1, local window after them.
  function automatic decode_t decodeAddr(input logic [OPADDR_W-1:0] a,
                                         input logic [LOCAL_W-1:0]  base);
    decode_t d;
    logic [LOCAL_W-1:0] off;
    d.valid = 1'b0;
    d.idx   = '0;
    off     = base + LOCAL_W'(a[OFFSET_W-1:0]);
    if (a[OPADDR_W-1]) begin
      d.valid = 1'b1;
      d.idx   = PHYS_W'(GLOBAL_CNT) + PHYS_W'(off);
    end else if (a[OFFSET_W-1:0] >= OFFSET_W'(GLOBAL_LO)) begin
      d.valid = 1'b1;
      d.idx   = PHYS_W'(a[OFFSET_W-1:0] - OFFSET_W'(GLOBAL_LO));
    end
    return d;
  endfunction
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            baseWrEn,
  input  logic [LOCAL_W-1:0]              baseWrData,
  input  logic [NUM_RD-1:0][OPADDR_W-1:0] rdAddr,
  input  logic                            intWrEn,
  input  logic [OPADDR_W-1:0]             intWrAddr,
  input  logic                            fpWrEn,
  input  logic [OPADDR_W-1:0]             fpWrAddr,
  output rfStrobes_t                      strobes,
  output logic                            unimplFlag,
  output logic                            collisionFlag
);
  logic [LOCAL_W-1:0]             localBase;
  decode_t                        intDec;
  decode_t                        fpDec;
  logic [NUM_RD-1:0]              rdValidV;
  logic [NUM_RD-1:0][PHYS_W-1:0]  rdIdxV;

  always_ff @(posedge clk) begin
    if (rst)           localBase <= '0;
    else if (baseWrEn) localBase <= baseWrData;
  end

  // R5
  base_load_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(baseWrEn) && !$past(rst)) |-> (localBase == $past(baseWrData)));

  always_comb begin
    intDec = decodeAddr(intWrAddr, localBase);
    fpDec  = decodeAddr(fpWrAddr, localBase);
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rdDec
    decode_t rdDec;
    always_comb rdDec = decodeAddr(rdAddr[g], localBase);
    assign rdValidV[g] = rdDec.valid;
    assign rdIdxV[g]   = rdDec.idx;
  end

  always_comb begin
    strobes.intWe   = intWrEn && intDec.valid;
    strobes.fpWe    = fpWrEn && fpDec.valid;
    strobes.intIdx  = intDec.idx;
    strobes.fpIdx   = fpDec.idx;
    strobes.rdValid = rdValidV;
    strobes.rdIdx   = rdIdxV;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unimplFlag    <= 1'b0;
      collisionFlag <= 1'b0;
    end else begin
      unimplFlag    <= (intWrEn && !intDec.valid) || (fpWrEn && !fpDec.valid);
      collisionFlag <= strobes.intWe && strobes.fpWe &&
                       (strobes.intIdx == strobes.fpIdx);
    end
  end

  // R3
  unimpl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    unimplFlag |-> $past((intWrEn && intWrAddr < OPADDR_W'(GLOBAL_LO)) ||
                         (fpWrEn && fpWrAddr < OPADDR_W'(GLOBAL_LO))));

  // R10
  collision_src_chk: assert property (@(posedge clk) disable iff (rst)
    collisionFlag |-> $past(intWrEn && fpWrEn && (intWrAddr == fpWrAddr) &&
                            (intWrAddr >= OPADDR_W'(GLOBAL_LO))));
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  rfStrobes_t                    strobes,
  input  logic [DATA_W-1:0]             intWrData,
  input  logic [DATA_W-1:0]             fpWrData,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [PHYS_DEPTH];

  // Floating-point write is applied last so it wins a same-entry clash.
  always_ff @(posedge clk) begin
    if (strobes.intWe) mem[strobes.intIdx] <= intWrData;
    if (strobes.fpWe)  mem[strobes.fpIdx]  <= fpWrData;
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rdPort
    always_comb begin
      if (!strobes.rdValid[g])
        rdData[g] = '0;
      else if (strobes.fpWe && strobes.fpIdx == strobes.rdIdx[g])
        rdData[g] = fpWrData;
      else if (strobes.intWe && strobes.intIdx == strobes.rdIdx[g])
        rdData[g] = intWrData;
      else
        rdData[g] = mem[strobes.rdIdx[g]];
    end
  end

  // R8
  fp_store_chk: assert property (@(posedge clk) disable iff (rst)
    $past(strobes.fpWe) |-> (mem[$past(strobes.fpIdx)] == $past(fpWrData)));

  // R7
  int_store_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(strobes.intWe) &&
     !($past(strobes.fpWe) && $past(strobes.fpIdx) == $past(strobes.intIdx)))
    |-> (mem[$past(strobes.intIdx)] == $past(intWrData)));
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
  import regfile_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                baseWrEn,
  input  logic [LOCAL_W-1:0]  baseWrData,
  input  logic [OPADDR_W-1:0] rdAddrA,
  input  logic [OPADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0]   rdDataA,
  output logic [DATA_W-1:0]   rdDataB,
  input  logic                intWrEn,
  input  logic [OPADDR_W-1:0] intWrAddr,
  input  logic [DATA_W-1:0]   intWrData,
  input  logic                fpWrEn,
  input  logic [OPADDR_W-1:0] fpWrAddr,
  input  logic [DATA_W-1:0]   fpWrData,
  output logic                unimplFlag,
  output logic                collisionFlag
);
  rfStrobes_t                     strobes;
  logic [NUM_RD-1:0][OPADDR_W-1:0] rdAddr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdData;

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  regfile_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .baseWrEn     (baseWrEn),
    .baseWrData   (baseWrData),
    .rdAddr       (rdAddr),
    .intWrEn      (intWrEn),
    .intWrAddr    (intWrAddr),
    .fpWrEn       (fpWrEn),
    .fpWrAddr     (fpWrAddr),
    .strobes      (strobes),
    .unimplFlag   (unimplFlag),
    .collisionFlag(collisionFlag)
  );

  regfile_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .intWrData(intWrData),
    .fpWrData (fpWrData),
    .rdData   (rdData)
  );

  // R2
  unimpl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((rdAddrA < OPADDR_W'(GLOBAL_LO)) |-> (rdDataA == '0)));
endmodule

// File: tb/windowed_regfile_bench.sv
module windowed_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst;
  logic        baseWrEn;
  logic [6:0]  baseWrData;
  logic [7:0]  rdAddrA, rdAddrB;
  logic [31:0] rdDataA, rdDataB;
  logic        intWrEn, fpWrEn;
  logic [7:0]  intWrAddr, fpWrAddr;
  logic [31:0] intWrData, fpWrData;
  logic        unimplFlag, collisionFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] mdl [192];
  int          base = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  windowed_regfile u_windowed_regfile (
    .clk(clk), .rst(rst), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .intWrEn(intWrEn), .intWrAddr(intWrAddr), .intWrData(intWrData),
    .fpWrEn(fpWrEn), .fpWrAddr(fpWrAddr), .fpWrData(fpWrData),
    .unimplFlag(unimplFlag), .collisionFlag(collisionFlag)
  );

  function automatic bit impl(input logic [7:0] a);
    return a[7] || a[6];
  endfunction

  function automatic int phys(input logic [7:0] a);
    if (a[7]) return 64 + ((base + int'(a[6:0])) % 128);
    return int'(a) - 64;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    if (!impl(a)) return 32'h0;
    if (fpWrEn && impl(fpWrAddr) && phys(fpWrAddr) == phys(a)) return fpWrData;
    if (intWrEn && impl(intWrAddr) && phys(intWrAddr) == phys(a)) return intWrData;
    return mdl[phys(a)];
  endfunction

  function automatic string classify(input logic [7:0] a);
    if (!impl(a)) return "R2";
    if ((fpWrEn && impl(fpWrAddr) && phys(fpWrAddr) == phys(a)) ||
        (intWrEn && impl(intWrAddr) && phys(intWrAddr) == phys(a))) return "R9";
    if (a[7]) return "R4";
    return "R1";
  endfunction

  function automatic logic [7:0] randAddr();
    case ($urandom % 4)
      0:       return 8'($urandom % 64);
      1:       return 8'(64 + $urandom % 64);
      default: return 8'(128 + $urandom % 128);
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    baseWrEn = 0; baseWrData = '0; intWrEn = 0; fpWrEn = 0;
    intWrAddr = '0; fpWrAddr = '0; intWrData = '0; fpWrData = '0;
    rdAddrA = '0; rdAddrB = '0;
  endtask

  // Inputs are set after a falling edge; reads checked 1 time unit later,
  // flags checked just after the rising edge that registers them.
  task automatic step(input string tag);
    logic [31:0] eA, eB;
    logic eU, eC;
    #1;
    eA = expRead(rdAddrA);
    eB = expRead(rdAddrB);
    check((tag != "") ? tag : classify(rdAddrA), rdDataA, eA);
    check((tag != "") ? tag : "R6", rdDataB, eB);
    eU = !rst && ((intWrEn && !impl(intWrAddr)) || (fpWrEn && !impl(fpWrAddr)));
    eC = !rst && intWrEn && fpWrEn && impl(intWrAddr) && (intWrAddr == fpWrAddr);
    @(posedge clk);
    if (intWrEn && impl(intWrAddr)) mdl[phys(intWrAddr)] = intWrData;
    if (fpWrEn && impl(fpWrAddr))   mdl[phys(fpWrAddr)]  = fpWrData;
    if (rst) base = 0;
    else if (baseWrEn) base = int'(baseWrData);
    #1;
    check(rst ? "R11" : "R3", {31'b0, unimplFlag}, {31'b0, eU});
    check(rst ? "R11" : "R10", {31'b0, collisionFlag}, {31'b0, eC});
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst = 1;
    @(negedge clk);
    step("R11");
    step("R11");
    rst = 0;

    // Fill every register: locals through the integer port, globals through fp (R8).
    for (int k = 0; k < 128; k++) begin
      idle();
      intWrEn = 1; intWrAddr = 8'(128 + k); intWrData = 32'hA000_0000 + k;
      fpWrEn = 1;  fpWrAddr = 8'(64 + (k % 64)); fpWrData = 32'hB000_0000 + k;
      step("");
    end
    idle(); rdAddrA = 8'd70; rdAddrB = 8'h85; step("R8");

    // R7: integer write seen in the following cycle.
    idle(); intWrEn = 1; intWrAddr = 8'd100; intWrData = 32'h1234_5678; step("");
    idle(); rdAddrA = 8'd100; rdAddrB = 8'd100; step("R7");

    // R5: base load takes effect next cycle; R4 wrap with base 120.
    idle(); baseWrEn = 1; baseWrData = 7'd120; rdAddrA = 8'h80; step("R5");
    idle(); rdAddrA = 8'h80; rdAddrB = 8'h8A; step("R4");

    // R3: unimplemented write ignored, flag is a single pulse.
    idle(); intWrEn = 1; intWrAddr = 8'd3; intWrData = 32'hDEAD_BEEF;
    rdAddrA = 8'd3; step("R3");
    idle(); rdAddrA = 8'd3; step("R3");
    idle(); fpWrEn = 1; fpWrAddr = 8'd63; fpWrData = 32'h1; rdAddrA = 8'd64; step("R3");

    // R10 and R9: same-register clash inside the window, read in the same cycle.
    idle(); intWrEn = 1; fpWrEn = 1; intWrAddr = 8'h90; fpWrAddr = 8'h90;
    intWrData = 32'h1111_1111; fpWrData = 32'h2222_2222;
    rdAddrA = 8'h90; rdAddrB = 8'h90; step("R9");
    idle(); rdAddrA = 8'h90; step("R10");

    // R9: integer-only bypass.
    idle(); intWrEn = 1; intWrAddr = 8'd127; intWrData = 32'h7777_0000;
    rdAddrA = 8'd127; step("R9");

    // R5/R11: reset mid-run clears base to zero.
    idle(); baseWrEn = 1; baseWrData = 7'd40; step("");
    idle(); rst = 1; step("R11");
    rst = 0;
    idle(); rdAddrA = 8'h80; rdAddrB = 8'h81; step("R5");

    // Random traffic with frequent address sharing.
    for (int i = 0; i < 3000; i++) begin
      idle();
      intWrEn = $urandom % 3 != 0; intWrAddr = randAddr(); intWrData = $urandom;
      fpWrEn  = $urandom % 3 == 0; fpWrData = $urandom;
      fpWrAddr = ($urandom % 4 == 0) ? intWrAddr : randAddr();
      rdAddrA = ($urandom % 4 == 0) ? intWrAddr : randAddr();
      rdAddrB = ($urandom % 4 == 0) ? fpWrAddr : randAddr();
      baseWrEn = $urandom % 16 == 0; baseWrData = 7'($urandom);
      step("");
    end

    finishRun();
  end
endmodule